// File: doc/BRIEF.md
# Cycle-Stealing Bitmap Video Generator

This block generates a 640x480-style raster at 25 MHz from a framebuffer held in a 16-bit SRAM that the CPU also uses. It drives the horizontal and vertical counters and the negative sync pulses. It also computes the word address of each video fetch, registers the fetched word and serializes it into pixels. The final colour comes from a 16-entry palette of 12-bit colours. A 512x400 picture window sits in the middle of the active area. The rest of the active area shows a border colour chosen by palette index, and the blanking intervals output black.

Each fetch reads one full word in a single cycle. In that cycle the block raises a clock-hold request, which keeps the CPU clock high so the CPU loses the cycle. In the 1-bit mode a word feeds 16 pixels, so one cycle in 16 is taken. In the 4-bit mode each pixel is doubled horizontally and each row is shown twice, giving a 256x200 image, and one cycle in 8 is taken. The CPU loses no cycles outside the window rows and columns. Sync levels and single-cycle falling-edge events are brought out for interrupt logic. The palette, border and mode are written through a small select/data write port.

Top module: `vid_steal_gen`

## Requirements
- R1: The horizontal counter runs over H_ACT+H_FP+H_SYNC+H_BP positions per line, and the line counter advances once per line over V_ACT+V_FP+V_SYNC+V_BP lines. `hsync_n` is low exactly at columns H_ACT+H_FP to H_ACT+H_FP+H_SYNC-1. `vsync_n` is low exactly on lines V_ACT+V_FP to V_ACT+V_FP+V_SYNC-1. Pixel and sync outputs lag the counter position by one cycle.
- R2: Outside the H_ACT x V_ACT active area the colour outputs are zero.
- R3: The window starts at column (H_ACT-WIN_W)/2 and line (V_ACT-WIN_H)/2 and spans WIN_W x WIN_H. Active positions outside the window show the palette entry selected by the border index.
- R4: In mode 0, window pixel (wx,wy) comes from the word at BASE + wy*(WIN_W/16) + wx/16. Columns wx%16 of 0..7 take the low byte and 8..15 take the high byte, in both cases from bit 7 down to bit 0. A bit of 0 shows palette entry 0 and a bit of 1 shows entry 15.
- R5: In mode 1, window pixel (wx,wy) comes from the word at BASE + (wy/2)*(WIN_W/8) + wx/8. The nibble is picked by (wx%8)/2 in the order bits 7:4, 3:0, 15:12, 11:8, and it indexes the palette directly. Each nibble covers two columns and each image row covers two lines.
- R6: `vid_rd` is high only on window lines. On such a line it pulses every 16 cycles in mode 0 and every 8 cycles in mode 1, WIN_W/16 or WIN_W/8 times per line. It is never high on two consecutive cycles.
- R7: Each fetch happens one slot before its pixels. The fetch for word k of a line occurs at window column k*S-S, where S is 16 or 8. Its address is the row base from R4 or R5 plus k.
- R8: `cpu_hold` is high in exactly the cycles where `vid_rd` is high.
- R9: `hs_fall` and `vs_fall` are high for one cycle, in the first cycle where `hsync_n` or `vsync_n` respectively is low.
- R10: A write with `cfg_sel`=0 sets the palette index (bits 3:0). A write with `cfg_sel`=1 writes bits 11:8/7:4/3:0 as red/green/blue into the entry at that index, and the index does not auto-increment. A write with `cfg_sel`=2 sets the border index (bits 3:0). A write with `cfg_sel`=3 sets the mode (bit 0). Writes take effect from the next cycle.
- R11: Reset is synchronous and active high. During reset the counters are at position 0, the sync outputs are high, the events are low and the colour is zero. Reset also sets palette entry i to grey {i,i,i}, border index 0, mode 0 and palette index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 12 | Configuration write data |
| vid_addr | output | ADDR_W | Word address of the video fetch |
| vid_rd | output | 1 | Video fetch strobe, word captured at clock edge |
| vid_data | input | 16 | Word returned by the SRAM |
| cpu_hold | output | 1 | Hold the CPU clock high this cycle |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hs_fall | output | 1 | One-cycle event on horizontal sync fall |
| vs_fall | output | 1 | One-cycle event on vertical sync fall |
| vga_r | output | 4 | Red level |
| vga_g | output | 4 | Green level |
| vga_b | output | 4 | Blue level |

## Verification
The bench shrinks the geometry to a 64x12 active area, porches of 2/4/2 columns and 1/2/1 lines, and a 32x8 window at BASE 0x1000. With these values a whole frame is 1152 cycles, so every output can be compared position by position over complete frames in both modes. In one frame the bench sees the window edges, the fetch that comes one slot before the window, the row repeat of mode 1, and both sync falls. The 16-column window offset is the smallest that still leaves room for the first mode-0 fetch ahead of the window.

// File: rtl/vid_pkg.sv
package vid_pkg;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb_t;

    typedef enum logic {
        MODE_MONO = 1'b0,
        MODE_NIB  = 1'b1
    } vmode_t;

    typedef enum logic [1:0] {
        CFG_PIDX   = 2'd0,
        CFG_PDATA  = 2'd1,
        CFG_BORDER = 2'd2,
        CFG_MODE   = 2'd3
    } cfg_sel_t;

    function automatic rgb_t grey_level(input logic [3:0] lvl);
        rgb_t c;
        c.r = lvl;
        c.g = lvl;
        c.b = lvl;
        return c;
    endfunction

endpackage

// File: rtl/vid_timing.sv
module vid_timing #(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int HW     = 10,
    parameter int VW     = 10
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          hs_low,
    output logic          vs_low,
    output logic          active
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
    localparam logic [HW-1:0] H_AEND = HW'(H_ACT);
    localparam logic [VW-1:0] V_AEND = VW'(V_ACT);
    localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SYNC);
    localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SYNC);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        hs_low = (hcnt >= HS_BEG) && (hcnt < HS_END);
        vs_low = (vcnt >= VS_BEG) && (vcnt < VS_END);
        active = (hcnt < H_AEND) && (vcnt < V_AEND);
    end

    // R1: the column counter returns to zero after the last position
    p_hcnt_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (hcnt == H_LAST) |=> (hcnt == '0));

    // R1: the line counter moves only at the end of a line
    p_vcnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (hcnt != H_LAST) |=> $stable(vcnt));

endmodule

// File: rtl/vid_palette.sv
module vid_palette
    import vid_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [11:0] cfg_wdata,
    input  logic [3:0]  pix_idx,
    output rgb_t        pix_rgb,
    output rgb_t        border_rgb,
    output vmode_t      mode
);
    rgb_t       pal [16];
    logic [3:0] sel_idx;
    logic [3:0] brd_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) pal[i] <= grey_level(4'(i));
            sel_idx <= '0;
            brd_idx <= '0;
            mode    <= MODE_MONO;
        end else if (cfg_we) begin
            case (cfg_sel_t'(cfg_sel))
                CFG_PIDX:   sel_idx      <= cfg_wdata[3:0];
                CFG_PDATA:  pal[sel_idx] <= rgb_t'(cfg_wdata);
                CFG_BORDER: brd_idx      <= cfg_wdata[3:0];
                CFG_MODE:   mode         <= vmode_t'(cfg_wdata[0]);
                default:    ;
            endcase
        end
    end

    assign pix_rgb    = pal[pix_idx];
    assign border_rgb = pal[brd_idx];

    // R10: a mode write is visible on the next cycle
    p_mode_write_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd3) |=> (mode == vmode_t'($past(cfg_wdata[0]))));

    // R10: the palette index changes only through its own select
    p_idx_only_sel0_r10: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_sel == 2'd0) |=> $stable(sel_idx));

endmodule

// File: rtl/vid_fetch.sv
module vid_fetch
    import vid_pkg::*;
#(
    parameter int H_ACT  = 640,
    parameter int V_ACT  = 480,
    parameter int WIN_W  = 512,
    parameter int WIN_H  = 400,
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW-1:0]     hcnt,
    input  logic [VW-1:0]     vcnt,
    input  vmode_t            mode,
    input  logic [15:0]       vid_data,
    output logic              vid_rd,
    output logic [ADDR_W-1:0] vid_addr,
    output logic              in_win,
    output logic [3:0]        pix_idx
);
    localparam int WX0 = (H_ACT - WIN_W) / 2;
    localparam int WY0 = (V_ACT - WIN_H) / 2;
    localparam int N0  = WIN_W / 16;
    localparam int N1  = WIN_W / 8;
    localparam logic [HW:0]   WX0_E = (HW+1)'(WX0);
    localparam logic [HW:0]   WX1_E = (HW+1)'(WX0 + WIN_W);
    localparam logic [VW-1:0] WY0_V = VW'(WY0);
    localparam logic [VW-1:0] WY1_V = VW'(WY0 + WIN_H);
    localparam logic [VW-1:0] VA_V  = VW'(V_ACT);

    logic [HW:0]   hx, nx, slot, mask, fxs, fx, wx, nwx, word_k;
    logic [VW-1:0] wy, row;
    logic          in_wx, in_wy, in_fx, in_nx, load;
    logic [15:0]   hold;
    logic [15:0]   cur;

    always_comb begin
        hx    = {1'b0, hcnt};
        nx    = hx + 1'b1;
        slot  = (mode == MODE_NIB) ? (HW+1)'(8) : (HW+1)'(16);
        mask  = slot - 1'b1;
        fxs   = hx + slot;
        fx    = fxs - WX0_E;
        wx    = hx - WX0_E;
        nwx   = nx - WX0_E;
        wy    = vcnt - WY0_V;
        in_wx = (hx >= WX0_E) && (hx < WX1_E);
        in_nx = (nx >= WX0_E) && (nx < WX1_E);
        in_fx = (fxs >= WX0_E) && (fxs < WX1_E);
        in_wy = (vcnt >= WY0_V) && (vcnt < WY1_V);
        vid_rd = in_wy && in_fx && ((fx & mask) == '0);
        load   = in_nx && ((nwx & mask) == '0);
        row    = (mode == MODE_NIB) ? (wy >> 1) : wy;
        word_k = (mode == MODE_NIB) ? (fx >> 3) : (fx >> 4);
        vid_addr = BASE + ADDR_W'(word_k)
                 + ((mode == MODE_NIB) ? ADDR_W'(row) * ADDR_W'(N1)
                                       : ADDR_W'(row) * ADDR_W'(N0));
        in_win  = in_wx && in_wy;
        pix_idx = (mode == MODE_MONO) ? {4{cur[15]}} : cur[15:12];
    end

    // hold: word fetched one slot early; cur: word being shown, leftmost byte on top
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            cur  <= '0;
        end else begin
            if (vid_rd) hold <= vid_data;
            if (load) begin
                cur <= {hold[7:0], hold[15:8]};
            end else if (in_wx) begin
                if (mode == MODE_MONO) cur <= cur << 1;
                else if (wx[0])        cur <= cur << 4;
            end
        end
    end

    // R6: fetches are at least one slot apart
    p_fetch_gap_r6: assert property (@(posedge clk) disable iff (rst)
        vid_rd |=> !vid_rd);

    // R6: no fetch on blanking lines
    p_nofetch_blank_r6: assert property (@(posedge clk) disable iff (rst)
        vid_rd |-> (vcnt < VA_V));

endmodule

// File: rtl/vid_steal_gen.sv
module vid_steal_gen
    import vid_pkg::*;
#(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int WIN_W  = 512,
    parameter int WIN_H  = 400,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [11:0]       cfg_wdata,
    output logic [ADDR_W-1:0] vid_addr,
    output logic              vid_rd,
    input  logic [15:0]       vid_data,
    output logic              cpu_hold,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              hs_fall,
    output logic              vs_fall,
    output logic [3:0]        vga_r,
    output logic [3:0]        vga_g,
    output logic [3:0]        vga_b
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          hs_low, vs_low, active, in_win;
    logic [3:0]    pix_idx;
    rgb_t          pix_rgb, border_rgb, out_q;
    vmode_t        mode;

    vid_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt),
        .hs_low(hs_low), .vs_low(vs_low), .active(active)
    );

    vid_fetch #(
        .H_ACT(H_ACT), .V_ACT(V_ACT), .WIN_W(WIN_W), .WIN_H(WIN_H),
        .HW(HW), .VW(VW), .ADDR_W(ADDR_W), .BASE(BASE)
    ) u_fetch (
        .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt), .mode(mode),
        .vid_data(vid_data), .vid_rd(vid_rd), .vid_addr(vid_addr),
        .in_win(in_win), .pix_idx(pix_idx)
    );

    vid_palette u_pal (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .border_rgb(border_rgb), .mode(mode)
    );

    assign cpu_hold = vid_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            hs_fall <= 1'b0;
            vs_fall <= 1'b0;
        end else begin
            out_q   <= !active ? '0 : (in_win ? pix_rgb : border_rgb);
            hsync_n <= !hs_low;
            vsync_n <= !vs_low;
            hs_fall <= hs_low & hsync_n;
            vs_fall <= vs_low & vsync_n;
        end
    end

    assign vga_r = out_q.r;
    assign vga_g = out_q.g;
    assign vga_b = out_q.b;

    // R2: blanking positions come out black one cycle later
    p_blank_black_r2: assert property (@(posedge clk) disable iff (rst)
        !active |=> (out_q == '0));

    // R9: sync events are single-cycle pulses
    p_hs_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        hs_fall |=> !hs_fall);

    // R9: a vertical event coincides with a low vertical sync
    p_vs_low_r9: assert property (@(posedge clk) disable iff (rst)
        vs_fall |-> !vsync_n);

endmodule

// File: tb/sim_vid_steal_gen.sv
`timescale 1ns/1ps
module sim_vid_steal_gen;
    localparam int H_ACT = 64, H_FP = 2, H_SYNC = 4, H_BP = 2;
    localparam int V_ACT = 12, V_FP = 1, V_SYNC = 2, V_BP = 1;
    localparam int WIN_W = 32, WIN_H = 8;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int FRAME = H_TOT * V_TOT;
    localparam int WX0 = (H_ACT - WIN_W) / 2;
    localparam int WY0 = (V_ACT - WIN_H) / 2;
    localparam logic [15:0] BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [11:0] cfg_wdata = '0;
    logic [15:0] vid_addr, vid_data;
    logic        vid_rd, cpu_hold, hsync_n, vsync_n, hs_fall, vs_fall;
    logic [3:0]  vga_r, vga_g, vga_b;

    int nchk = 0;
    int nerr = 0;
    int ocyc = 0;

    logic [11:0] pal_m [16];
    logic [3:0]  brd_m = 4'd0;
    logic [3:0]  idx_m = 4'd0;
    logic        mode_m = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return (a * 16'h9E37) ^ (a >> 2) ^ 16'hC35A;
    endfunction

    assign vid_data = mem_word(vid_addr);

    vid_steal_gen #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .WIN_W(WIN_W), .WIN_H(WIN_H), .ADDR_W(16), .BASE(BASE)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vid_addr(vid_addr), .vid_rd(vid_rd),
        .vid_data(vid_data), .cpu_hold(cpu_hold), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .hs_fall(hs_fall), .vs_fall(vs_fall),
        .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
    );

    always @(posedge clk) begin
        if (rst) ocyc <= 0;
        else     ocyc <= ocyc + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic bit hs_low_m(input int x);
        return (x >= H_ACT + H_FP) && (x < H_ACT + H_FP + H_SYNC);
    endfunction

    function automatic bit vs_low_m(input int y);
        return (y >= V_ACT + V_FP) && (y < V_ACT + V_FP + V_SYNC);
    endfunction

    // expected fetch at counter position p; returns 1 with address if fetched
    function automatic bit fetch_m(input int p, output logic [15:0] a);
        int x = p % H_TOT;
        int y = p / H_TOT;
        int s = mode_m ? 8 : 16;
        int fx = x + s - WX0;
        int row = mode_m ? (y - WY0) / 2 : (y - WY0);
        a = '0;
        if (y < WY0 || y >= WY0 + WIN_H) return 1'b0;
        if (fx < 0 || fx >= WIN_W || (fx % s) != 0) return 1'b0;
        a = 16'(BASE + row * (WIN_W / s) + fx / s);
        return 1'b1;
    endfunction

    task automatic check_pos();
        int op = (ocyc - 1) % FRAME;
        int pp = (op + FRAME - 1) % FRAME;
        int fp = ocyc % FRAME;
        int x = op % H_TOT, y = op / H_TOT;
        int px = pp % H_TOT, py = pp / H_TOT;
        int wx = x - WX0, wy = y - WY0;
        logic [11:0] exp_c;
        logic [15:0] w, fa;
        logic [7:0]  byt;
        logic [3:0]  ix;
        string req;
        bit erd;
        check("R1", "hsync_n", 16'(hsync_n), 16'(!hs_low_m(x)));
        check("R1", "vsync_n", 16'(vsync_n), 16'(!vs_low_m(y)));
        check("R9", "hs_fall", 16'(hs_fall), 16'(hs_low_m(x) && !hs_low_m(px)));
        check("R9", "vs_fall", 16'(vs_fall), 16'(vs_low_m(y) && !vs_low_m(py)));
        if (x >= H_ACT || y >= V_ACT) begin
            req = "R2"; exp_c = 12'h000;
        end else if (wx < 0 || wx >= WIN_W || wy < 0 || wy >= WIN_H) begin
            req = "R3"; exp_c = pal_m[brd_m];
        end else if (!mode_m) begin
            req = "R4";
            w = mem_word(16'(BASE + wy * (WIN_W / 16) + wx / 16));
            byt = ((wx % 16) < 8) ? w[7:0] : w[15:8];
            ix = byt[7 - (wx % 8)] ? 4'd15 : 4'd0;
            exp_c = pal_m[ix];
        end else begin
            req = "R5";
            w = mem_word(16'(BASE + (wy / 2) * (WIN_W / 8) + wx / 8));
            case ((wx % 8) / 2)
                0: ix = w[7:4];
                1: ix = w[3:0];
                2: ix = w[15:12];
                default: ix = w[11:8];
            endcase
            exp_c = pal_m[ix];
        end
        check(req, "colour", 16'({vga_r, vga_g, vga_b}), 16'(exp_c));
        erd = fetch_m(fp, fa);
        check("R6", "vid_rd", 16'(vid_rd), 16'(erd));
        check("R8", "cpu_hold", 16'(cpu_hold), 16'(erd));
        if (erd) check("R7", "vid_addr", vid_addr, fa);
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: idx_m = d[3:0];
            2'd1: pal_m[idx_m] = d;
            2'd2: brd_m = d[3:0];
            default: mode_m = d[0];
        endcase
    endtask

    task automatic scan_frame();
        do @(negedge clk); while (ocyc < 1 || ((ocyc - 1) % FRAME) != 0);
        for (int i = 0; i < FRAME; i++) begin
            check_pos();
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) pal_m[i] = {4'(i), 4'(i), 4'(i)};
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "hsync_n in reset", 16'(hsync_n), 16'd1);
        check("R11", "vsync_n in reset", 16'(vsync_n), 16'd1);
        check("R11", "events in reset", 16'({hs_fall, vs_fall}), 16'd0);
        check("R11", "colour in reset", 16'({vga_r, vga_g, vga_b}), 16'd0);
        check("R11", "no fetch in reset", 16'(vid_rd), 16'd0);
        rst = 1'b0;
    endtask

    task automatic t_mono_default();
        scan_frame();
    endtask

    task automatic t_palette_border();
        cfg_write(2'd0, 12'd0);
        cfg_write(2'd1, 12'h1A3);
        cfg_write(2'd0, 12'd15);
        cfg_write(2'd1, 12'hE52);
        cfg_write(2'd0, 12'd9);
        cfg_write(2'd1, 12'h36C);
        cfg_write(2'd2, 12'd9);
        scan_frame();
    endtask

    task automatic t_nibble_mode();
        cfg_write(2'd3, 12'd1);
        cfg_write(2'd0, 12'd5);
        cfg_write(2'd1, 12'h0F0);
        cfg_write(2'd0, 12'd10);
        cfg_write(2'd1, 12'hA0A);
        scan_frame();
    endtask

    task automatic t_index_no_increment();
        cfg_write(2'd0, 12'd4);
        cfg_write(2'd1, 12'h111);
        cfg_write(2'd1, 12'h7B2);
        cfg_write(2'd2, 12'd4);
        scan_frame();
        // R10: border of entry 4 must show the second data write
        check("R10", "entry 4 not incremented", 16'(pal_m[4]), 16'h7B2);
    endtask

    task automatic t_back_to_mono();
        cfg_write(2'd3, 12'd0);
        scan_frame();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R11 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_mono_default();
        t_palette_border();
        t_nibble_mode();
        t_index_no_increment();
        t_back_to_mono();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule